// File: doc/BRIEF.md
# ARINC 429 Word Receiver

This block takes one ARINC 429 channel after the analog front end. The front end has already reduced the line to two digital levels, `lineHi` and `lineLo`. The block samples the line at ten samples per nominal bit. It decodes the return-to-zero bits and measures every data interval and every null interval against a tolerance window. Any word whose timing falls outside that window is discarded. A complete word of 32 bits is kept in a holding register. In that register the last bit position is replaced by the outcome of an odd-parity check.

A host collects the word over a 16-bit bus in two reads. The `ready` output signals that a word is waiting. One speed-select input chooses the sample rate, so the same tolerance rules apply to both line speeds:

- Fast rate: `HI_DIV` clocks per sample.
- Slow rate: eight times longer per sample (the parameter `LO_MULT`).

Top module: `rx429_rx`

## Requirements
- R1: A sample is taken once every `HI_DIV` clocks when `spdSel`=1, and once every `HI_DIV*LO_MULT` clocks when `spdSel`=0. A nominal bit is 10 samples. A word timed for one speed is discarded when the other speed is selected.
- R2: The sampled line level is decoded as follows:
  - `lineHi`=1 and `lineLo`=0: a data one.
  - `lineHi`=0 and `lineLo`=1: a data zero.
  - Both low: null.
  - Both high: invalid, and the word is discarded.
- R3: Each data interval must last between 3 and 7 samples inclusive, otherwise the word is discarded.
- R4: Inside a word, each null interval must last at least 3 samples. The bit period, measured from one data start to the next, must be 8 to 12 samples. Any other timing discards the word.
- R5: A null lasting 40 samples ends a word. Only a word of exactly 32 bits is kept. A word with fewer bits, or with a 33rd bit before the gap, is discarded.
- R6: The first bit received lands in bit index 0 (bit 0 of the low half). Bit k lands in index k-1, up to index 30.
- R7: Stored index 31 (bit 15 of the high half) is 1 when the 32 received bits hold an odd number of ones, and 0 otherwise.
- R8: The read pointer and `ready` behave as follows:
  - `rdData` shows bits 15..0 while the read pointer is at the first half.
  - A `rdStrobe` pulse moves the pointer to bits 31..16 and leaves `ready` set.
  - A second pulse returns the pointer to the first half and clears `ready`.
- R9: After reset, `ready`=0 and `rdData`=0. `ready` sets when a valid word is stored.
- R10: A new valid word overwrites the holding register even when unread. It returns the pointer to the first half, and `ready` stays set.
- R11: After a discarded word, the receiver waits for a 40-sample null. It then accepts the next valid word.
- R12: A change from one data level directly to the other data level, with no null between them, discards the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spdSel | input | 1 | 1 selects the fast sample rate, 0 the slow one |
| lineHi | input | 1 | Digital line-high level from the front end |
| lineLo | input | 1 | Digital line-low level from the front end |
| rdStrobe | input | 1 | One-cycle read pulse; advances the half pointer |
| rdData | output | 16 | Selected half of the held word |
| ready | output | 1 | A stored word is waiting to be read |

## Verification
The hardest cases to reach are the exact tolerance edges, for example a 3-sample data interval against a 2-sample one. These depend on how many sample ticks fall inside an interval driven from outside. The stimulus makes each interval an exact multiple of the current sample period, so every interval covers a known number of ticks whatever the prescaler phase is. This lets each boundary be hit on both sides. Each rejection is followed by a valid word, which also checks recovery after the gap. Speed mismatch is exercised by driving slow-rate timing with the fast rate selected, and the reverse.

// File: rtl/rx429_pkg.sv
package rx429_pkg;

  // decoded line level of one sample
  typedef enum logic [1:0] {
    LVL_NULL = 2'd0,
    LVL_ONE  = 2'd1,
    LVL_ZERO = 2'd2,
    LVL_BAD  = 2'd3
  } lvl_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftVal;
    logic storeEn;
  } rxStrobe_t;

endpackage

// File: rtl/rx429_ctrl.sv
module rx429_ctrl
  import rx429_pkg::*;
#(
  parameter int WORD_BITS   = 32,
  parameter int DATA_MIN    = 3,
  parameter int DATA_MAX    = 7,
  parameter int NULL_MIN    = 3,
  parameter int PER_MIN     = 8,
  parameter int PER_MAX     = 12,
  parameter int GAP_SAMPLES = 40
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  lvl_e      lvl,
  output rxStrobe_t strobe
);

  localparam int CW = $clog2(GAP_SAMPLES + 2);
  localparam int BW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] ONE_C   = CW'(1);
  localparam logic [CW-1:0] DMIN_C  = CW'(DATA_MIN);
  localparam logic [CW-1:0] DMAX_C  = CW'(DATA_MAX);
  localparam logic [CW-1:0] NMIN_C  = CW'(NULL_MIN);
  localparam logic [CW-1:0] PMIN_C  = CW'(PER_MIN);
  localparam logic [CW-1:0] PMAX_C  = CW'(PER_MAX);
  localparam logic [CW-1:0] GAP_C   = CW'(GAP_SAMPLES);
  localparam logic [BW-1:0] WORD_C  = BW'(WORD_BITS);
  localparam logic [BW-1:0] BONE_C  = BW'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_NULL, ST_ERR} st_e;

  st_e           state, stateN;
  logic [CW-1:0] runCnt, runN;
  logic [CW-1:0] perCnt, perN;
  logic [BW-1:0] bitCnt, bitN;
  logic          curOne, oneN;
  lvl_e          curLvl;
  logic          isData;

  assign curLvl = curOne ? LVL_ONE : LVL_ZERO;
  assign isData = (lvl == LVL_ONE) || (lvl == LVL_ZERO);

  always_comb begin
    stateN = state;
    runN   = runCnt;
    perN   = perCnt;
    bitN   = bitCnt;
    oneN   = curOne;
    strobe = '0;
    strobe.shiftVal = curOne;
    if (tick) begin
      unique case (state)
        ST_IDLE: begin
          if (isData) begin
            stateN = ST_DATA;
            runN   = ONE_C;
            perN   = ONE_C;
            bitN   = '0;
            oneN   = (lvl == LVL_ONE);
          end else if (lvl == LVL_BAD) begin
            stateN = ST_ERR;
            runN   = '0;
          end
        end
        ST_DATA: begin
          if (lvl == curLvl) begin
            if (runCnt >= DMAX_C) begin
              stateN = ST_ERR;
              runN   = '0;
            end else begin
              runN = runCnt + ONE_C;
              perN = perCnt + ONE_C;
            end
          end else if (lvl == LVL_NULL) begin
            if (runCnt < DMIN_C) begin
              stateN = ST_ERR;
              runN   = '0;
            end else begin
              strobe.shiftEn = 1'b1;
              bitN   = bitCnt + BONE_C;
              stateN = ST_NULL;
              runN   = ONE_C;
              perN   = perCnt + ONE_C;
            end
          end else begin
            stateN = ST_ERR;
            runN   = '0;
          end
        end
        ST_NULL: begin
          if (lvl == LVL_NULL) begin
            if (bitCnt == WORD_C) begin
              if (runCnt + ONE_C >= GAP_C) begin
                strobe.storeEn = 1'b1;
                stateN = ST_IDLE;
                runN   = '0;
              end else begin
                runN = runCnt + ONE_C;
              end
            end else if (perCnt >= PMAX_C) begin
              stateN = ST_ERR;
              runN   = '0;
            end else begin
              runN = runCnt + ONE_C;
              perN = perCnt + ONE_C;
            end
          end else if (isData) begin
            if ((bitCnt == WORD_C) || (runCnt < NMIN_C) || (perCnt < PMIN_C)) begin
              stateN = ST_ERR;
              runN   = '0;
            end else begin
              stateN = ST_DATA;
              runN   = ONE_C;
              perN   = ONE_C;
              oneN   = (lvl == LVL_ONE);
            end
          end else begin
            stateN = ST_ERR;
            runN   = '0;
          end
        end
        ST_ERR: begin
          if (lvl == LVL_NULL) begin
            if (runCnt + ONE_C >= GAP_C) begin
              stateN = ST_IDLE;
              runN   = '0;
            end else begin
              runN = runCnt + ONE_C;
            end
          end else begin
            runN = '0;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      runCnt <= '0;
      perCnt <= '0;
      bitCnt <= '0;
      curOne <= 1'b0;
    end else begin
      state  <= stateN;
      runCnt <= runN;
      perCnt <= perN;
      bitCnt <= bitN;
      curOne <= oneN;
    end
  end

  // R5
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= WORD_C);

  // R2
  shift_on_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |-> (tick && lvl == LVL_NULL));

  // R5
  store_on_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |-> (tick && lvl == LVL_NULL));

endmodule

// File: rtl/rx429_dp.sv
module rx429_dp
  import rx429_pkg::*;
#(
  parameter int WORD_BITS   = 32,
  parameter int HI_DIV      = 4,
  parameter int LO_MULT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spdSel,
  input  logic                   lineHi,
  input  logic                   lineLo,
  input  logic                   rdStrobe,
  input  rxStrobe_t              strobe,
  output logic                   tick,
  output lvl_e                   lvl,
  output logic                   ready,
  output logic [WORD_BITS/2-1:0] rdData
);

  localparam int HALF_W = WORD_BITS / 2;
  localparam int LO_DIV = HI_DIV * LO_MULT;
  localparam int PW     = $clog2(LO_DIV + 1);
  localparam logic [PW-1:0] HI_LIM = PW'(HI_DIV - 1);
  localparam logic [PW-1:0] LO_LIM = PW'(LO_DIV - 1);
  localparam logic [PW-1:0] P_ONE  = PW'(1);

  // sample prescaler
  logic [PW-1:0] preCnt;
  logic [PW-1:0] divLim;
  assign divLim = spdSel ? HI_LIM : LO_LIM;
  assign tick   = (preCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= tick ? '0 : preCnt + P_ONE;
  end

  // line synchronizers
  logic [SYNC_STAGES-1:0] syncHi, syncLo;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncHi <= '0;
          syncLo <= '0;
        end else begin
          syncHi <= lineHi;
          syncLo <= lineLo;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncHi <= '0;
          syncLo <= '0;
        end else begin
          syncHi <= {syncHi[SYNC_STAGES-2:0], lineHi};
          syncLo <= {syncLo[SYNC_STAGES-2:0], lineLo};
        end
      end
    end
  endgenerate

  always_comb begin
    unique case ({syncHi[SYNC_STAGES-1], syncLo[SYNC_STAGES-1]})
      2'b10:   lvl = LVL_ONE;
      2'b01:   lvl = LVL_ZERO;
      2'b11:   lvl = LVL_BAD;
      default: lvl = LVL_NULL;
    endcase
  end

  // word assembly, first bit ends at index 0
  logic [WORD_BITS-1:0] shiftReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {strobe.shiftVal, shiftReg[WORD_BITS-1:1]};
  end

  logic                 parityOdd;
  logic [WORD_BITS-1:0] storeWord;
  assign parityOdd = ^shiftReg;
  assign storeWord = {parityOdd, shiftReg[WORD_BITS-2:0]};

  // holding register and host read pointer
  logic [WORD_BITS-1:0] holdReg;
  logic                 halfSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      ready   <= 1'b0;
      halfSel <= 1'b0;
    end else if (strobe.storeEn) begin
      holdReg <= storeWord;
      ready   <= 1'b1;
      halfSel <= 1'b0;
    end else if (rdStrobe) begin
      halfSel <= ~halfSel;
      if (halfSel) ready <= 1'b0;
    end
  end

  assign rdData = halfSel ? holdReg[WORD_BITS-1:HALF_W] : holdReg[HALF_W-1:0];

  // R9
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(strobe.storeEn));

  // R8
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && halfSel && !strobe.storeEn) |=> !ready);

  // R10
  store_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEn |=> (ready && !halfSel));

  generate
    if (HI_DIV > 1) begin : g_tickChk
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rx429_rx.sv
module rx429_rx
  import rx429_pkg::*;
#(
  parameter int WORD_BITS   = 32,
  parameter int HI_DIV      = 4,
  parameter int LO_MULT     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_MIN    = 3,
  parameter int DATA_MAX    = 7,
  parameter int NULL_MIN    = 3,
  parameter int PER_MIN     = 8,
  parameter int PER_MAX     = 12,
  parameter int GAP_SAMPLES = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   spdSel,
  input  logic                   lineHi,
  input  logic                   lineLo,
  input  logic                   rdStrobe,
  output logic [WORD_BITS/2-1:0] rdData,
  output logic                   ready
);

  rxStrobe_t strobe;
  logic      tick;
  lvl_e      lvl;

  rx429_ctrl #(
    .WORD_BITS(WORD_BITS), .DATA_MIN(DATA_MIN), .DATA_MAX(DATA_MAX),
    .NULL_MIN(NULL_MIN), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
    .GAP_SAMPLES(GAP_SAMPLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .lvl(lvl), .strobe(strobe)
  );

  rx429_dp #(
    .WORD_BITS(WORD_BITS), .HI_DIV(HI_DIV), .LO_MULT(LO_MULT),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .spdSel(spdSel), .lineHi(lineHi),
    .lineLo(lineLo), .rdStrobe(rdStrobe), .strobe(strobe),
    .tick(tick), .lvl(lvl), .ready(ready), .rdData(rdData)
  );

endmodule

// File: tb/rx429_rx_tb_top.sv
module rx429_rx_tb_top;

  localparam int HI_DIV  = 4;
  localparam int LO_MULT = 8;
  localparam int LO_DIV  = HI_DIV * LO_MULT;
  localparam int GAP     = 40;

  typedef struct packed {
    logic        spd;
    logic [31:0] word;
    logic [3:0]  dLen;
    logic [3:0]  nLen;
    logic        ok;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{1'b1, 32'h8000_0001, 4'd5, 4'd5, 1'b1},  // nominal, even parity
    '{1'b1, 32'hFFFF_FFFF, 4'd3, 4'd5, 1'b1},  // data min, period 8
    '{1'b1, 32'h1234_5678, 4'd7, 4'd5, 1'b1},  // data max, period 12
    '{1'b1, 32'hA5A5_0F0F, 4'd2, 4'd6, 1'b0},  // data too short
    '{1'b1, 32'h0000_0000, 4'd8, 4'd3, 1'b0},  // data too long
    '{1'b1, 32'hDEAD_BEEF, 4'd7, 4'd2, 1'b0},  // null too short
    '{1'b1, 32'h5555_AAAA, 4'd5, 4'd8, 1'b0},  // period 13
    '{1'b1, 32'h0F0F_0F0E, 4'd4, 4'd3, 1'b0},  // period 7
    '{1'b1, 32'h7FFF_FFFE, 4'd6, 4'd6, 1'b1},  // odd/even mix
    '{1'b0, 32'hC3C3_3C3D, 4'd5, 4'd5, 1'b1}   // slow rate
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spdSel = 1'b1;
  logic        lineHi = 1'b0;
  logic        lineLo = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;
  logic        ready;

  int chkCnt = 0;
  int errCnt = 0;

  always #2 clk = ~clk;

  rx429_rx #(.HI_DIV(HI_DIV), .LO_MULT(LO_MULT)) dut_i (
    .clk(clk), .rstN(rstN), .spdSel(spdSel), .lineHi(lineHi),
    .lineLo(lineLo), .rdStrobe(rdStrobe), .rdData(rdData), .ready(ready)
  );

  function automatic logic [31:0] expWord(input logic [31:0] w);
    return {^w, w[30:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic hi, input logic lo, input int n, input int div);
    lineHi = hi;
    lineLo = lo;
    repeat (n * div) @(negedge clk);
  endtask

  // badMode: 0 none, 1 both lines high, 2 direct data-level flip
  task automatic sendWord(input logic [31:0] w, input int nBits, input int dLen,
                          input int nLen, input int div, input int badBit, input int badMode);
    for (int i = 0; i < nBits; i++) begin
      logic b;
      b = (i < 32) ? w[i] : 1'b1;
      if (i == badBit && badMode == 1) drive(1'b1, 1'b1, dLen, div);
      else if (i == badBit && badMode == 2) begin
        drive(b, !b, 2, div);
        drive(!b, b, dLen - 2, div);
      end else drive(b, !b, dLen, div);
      drive(1'b0, 1'b0, (i == nBits - 1) ? GAP + 10 : nLen, div);
    end
  endtask

  task automatic setSpeed(input logic s);
    @(negedge clk);
    spdSel = s;
    repeat (2 * LO_DIV) @(negedge clk);
  endtask

  task automatic pulse();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic readWord(output logic [31:0] got);
    got[15:0] = rdData;
    pulse();
    got[31:16] = rdData;
    pulse();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [31:0] got;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9 reset ready", {31'd0, ready}, 32'd0);
    chk("R9 reset rdData", {16'd0, rdData}, 32'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R3 R4 R6 R7, rejections followed by accepts cover R11
    for (int v = 0; v < 10; v++) begin
      int div;
      div = VECS[v].spd ? HI_DIV : LO_DIV;
      setSpeed(VECS[v].spd);
      sendWord(VECS[v].word, 32, VECS[v].dLen, VECS[v].nLen, div, -1, 0);
      chk("R3 R4 R1 vec ready", {31'd0, ready}, {31'd0, VECS[v].ok});
      if (VECS[v].ok && ready) begin
        readWord(got);
        chk("R6 R7 vec word", got, expWord(VECS[v].word));
        chk("R8 vec ready cleared", {31'd0, ready}, 32'd0);
      end
    end

    // R7 odd parity explicit: one set bit gives parity bit 1
    setSpeed(1'b1);
    sendWord(32'h0000_0001, 32, 5, 5, HI_DIV, -1, 0);
    readWord(got);
    chk("R7 odd parity", got, 32'h8000_0001);
    // R6 bit order: bit 2 set only
    sendWord(32'h0000_0004, 32, 5, 5, HI_DIV, -1, 0);
    readWord(got);
    chk("R6 bit order", got, 32'h8000_0004);

    // R5 too few bits
    sendWord(32'h1111_1111, 31, 5, 5, HI_DIV, -1, 0);
    chk("R5 31 bits", {31'd0, ready}, 32'd0);
    // R5 too many bits
    sendWord(32'h2222_2222, 33, 5, 5, HI_DIV, -1, 0);
    chk("R5 33 bits", {31'd0, ready}, 32'd0);
    // R11 recovery
    sendWord(32'h3333_3333, 32, 5, 5, HI_DIV, -1, 0);
    chk("R11 recover ready", {31'd0, ready}, 32'd1);
    readWord(got);
    chk("R11 recover word", got, expWord(32'h3333_3333));

    // R2 both lines high
    sendWord(32'h4444_4444, 32, 5, 5, HI_DIV, 10, 1);
    chk("R2 invalid level", {31'd0, ready}, 32'd0);
    // R12 direct flip
    sendWord(32'h5555_5555, 32, 5, 5, HI_DIV, 5, 2);
    chk("R12 level flip", {31'd0, ready}, 32'd0);

    // R1 slow timing with fast rate selected
    sendWord(32'h6666_6666, 32, 5, 5, LO_DIV, -1, 0);
    chk("R1 slow on fast", {31'd0, ready}, 32'd0);
    // R1 fast timing with slow rate selected
    setSpeed(1'b0);
    sendWord(32'h7777_7777, 32, 5, 5, HI_DIV, -1, 0);
    drive(1'b0, 1'b0, GAP + 10, LO_DIV);
    chk("R1 fast on slow", {31'd0, ready}, 32'd0);
    setSpeed(1'b1);

    // R8 pointer and ready sequencing
    sendWord(32'h89AB_CDEF, 32, 5, 5, HI_DIV, -1, 0);
    chk("R9 ready set", {31'd0, ready}, 32'd1);
    chk("R8 low half", {16'd0, rdData}, 32'h0000_CDEF);
    pulse();
    chk("R8 ready after first", {31'd0, ready}, 32'd1);
    chk("R8 high half", {16'd0, rdData}, {16'd0, expWord(32'h89AB_CDEF)} >> 16);
    pulse();
    chk("R8 ready after second", {31'd0, ready}, 32'd0);
    chk("R8 pointer back low", {16'd0, rdData}, 32'h0000_CDEF);

    // R10 overwrite while partly read
    sendWord(32'h0123_4567, 32, 5, 5, HI_DIV, -1, 0);
    pulse();
    sendWord(32'hFEDC_BA98, 32, 5, 5, HI_DIV, -1, 0);
    chk("R10 ready kept", {31'd0, ready}, 32'd1);
    chk("R10 pointer low", {16'd0, rdData}, 32'h0000_BA98);
    readWord(got);
    chk("R10 new word", got, expWord(32'hFEDC_BA98));

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule